// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block runs the external memory bus of an 8-bit microcontroller whose low address byte and data share one set of lines. It counts oscillator clocks into machine cycles of twelve clocks each. In each cycle it raises the address latch strobe, the low-active program fetch strobe and the low-active read and write strobes at fixed phases. It also drives the shared low address/data lines with an output enable, and the high address byte.

A simple core model presents one request per machine cycle: a code fetch, an external data read or an external data write. With the request come the address, the write data, a flag for 16-bit or 8-bit data addressing, and a bit that quiets the free-running address latch strobe. The block also takes the external-access pin, which sends every code fetch off chip, and the contents of the high port's output register, which appear on the high address byte whenever the bus does not need it. The block captures the request at the clock edge that opens a machine cycle and holds it for the whole cycle.

The reset input is filtered. It takes effect only after it has stayed high for two whole machine cycles. The block powers up in the reset state.

Top module: `ext_bus_sequencer`

## Requirements
- R1: A machine cycle lasts 12 clocks, numbered as phases 0 to 11 from the edge that opens it. In cycles with no external access where the captured ale_quiet is 0, and in every external fetch cycle, ale is high on phases 0-2 and 6-8 and low on all other phases.
- R2: In an external data cycle, ale is high on phases 0-2 only, so the second pulse of the cycle is dropped.
- R3: When ale_quiet is captured as 1 in a cycle with no external access, ale stays low for the whole cycle. A data cycle still gives its single pulse.
- R4: The captured ale_quiet has no effect in an external fetch cycle.
- R5: In an external fetch cycle, psen_n is low on phases 3-5 and 9-11. In every other cycle, including data cycles, psen_n stays high.
- R6: A code fetch goes external when ea_n is 0, whatever the address, or when addr is 0x1000 or above. An internal fetch cycle drives the bus exactly like an idle cycle.
- R7: In a data cycle, rd_n (for a read) or wr_n (for a write) is low on phases 6-11 and high otherwise. If both are requested, the read wins. A data request takes precedence over a fetch.
- R8: In external cycles, ad_oe is 1 and ad_out carries addr[7:0] on phases 0-2. A fetch drives the low byte of addr+1 on phases 6-8. A write drives wr_data on phases 3-11. At every other phase, and in idle cycles, ad_oe is 0 and ad_out is 0.
- R9: hi_addr carries addr[15:8] on phases 0-5 of a fetch and (addr+1)[15:8] on phases 6-11. It carries addr[15:8] in a data cycle with data_wide=1. Otherwise it follows hi_port_reg as it changes.
- R10: fetch_req, data_rd_req, data_wr_req, addr, wr_data, data_wide, ale_quiet and ea_n are sampled only at the edge that opens a machine cycle. Changing them later in the cycle has no effect on that cycle.
- R11: rst held high for 24 consecutive edges puts the block in reset. In reset, ale is 0, psen_n, rd_n and wr_n are 1, ad_oe is 0 and hi_addr follows hi_port_reg. A high pulse of 23 edges or fewer has no effect. After rst falls, phase 0 starts at the second edge with rst low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Reset request, active high, filtered over two machine cycles |
| ea_n | input | 1 | External-access pin; low sends all code fetches off chip |
| fetch_req | input | 1 | Core requests a code fetch this cycle |
| data_rd_req | input | 1 | Core requests an external data read |
| data_wr_req | input | 1 | Core requests an external data write |
| data_wide | input | 1 | Data access uses a 16-bit address |
| ale_quiet | input | 1 | Suppress the free-running address latch strobe |
| addr | input | 16 | Access address |
| wr_data | input | 8 | Data for an external write |
| hi_port_reg | input | 8 | High port output-register contents |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | External data read strobe, active low |
| wr_n | output | 1 | External data write strobe, active low |
| ad_out | output | 8 | Multiplexed low address / data value |
| ad_oe | output | 1 | Drive enable for ad_out; 0 means released |
| hi_addr | output | 8 | High address byte / high port value |

## Verification
The quiet bit for the latch strobe and the access type are both settled by the one capture that opens a cycle, so they always fall in the same cycle. A quiet cycle must still pulse fully when it is an external fetch and pulse once when it is a data access. Directed cycles combine the quiet bit with each access type, including fetches sent off chip by ea_n and by the address limit. Random request traffic, captured at arbitrary phases, then mixes the two further. The bench's own phase model judges the latch strobe on every clock against the phase sets in the requirements.

// File: rtl/ext_bus_pkg.sv
`timescale 1ns/1ps
package ext_bus_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_DRD   = 2'd2,
    CYC_DWR   = 2'd3
  } cyc_kind_t;

  // A fetch leaves the chip when the pin forces it or the address is past on-chip code
  function automatic logic fetch_goes_out(input logic ea_low_n, input logic [31:0] a,
                                          input logic [31:0] limit);
    return (!ea_low_n) || (a >= limit);
  endfunction

  // Data accesses win over fetches, reads over writes
  function automatic cyc_kind_t pick_kind(input logic fetch, input logic rd, input logic wr,
                                          input logic ext_fetch);
    if (rd)                    return CYC_DRD;
    else if (wr)               return CYC_DWR;
    else if (fetch && ext_fetch) return CYC_FETCH;
    else                       return CYC_IDLE;
  endfunction

  // Address of the second code byte fetched in one machine cycle
  function automatic logic [31:0] second_code_addr(input logic [31:0] a);
    return a + 32'd1;
  endfunction

endpackage

// File: rtl/bus_phase_gen.sv
`timescale 1ns/1ps
module bus_phase_gen #(
  parameter int STATE_TICKS = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  output logic                                  core_rst,
  output logic [$clog2(6*STATE_TICKS)-1:0]      phase,
  output logic                                  cyc_start,
  output logic                                  ale_slot,
  output logic                                  second_half
);
  localparam int CYCLE_LEN  = 6 * STATE_TICKS;
  localparam int HALF_LEN   = CYCLE_LEN / 2;
  localparam int ALE_LEN    = HALF_LEN / 2;
  localparam int PH_W       = $clog2(CYCLE_LEN);
  localparam int RST_CYCLES = 2 * CYCLE_LEN;
  localparam int RC_W       = $clog2(RST_CYCLES + 1);
  localparam logic [PH_W-1:0] LAST = PH_W'(CYCLE_LEN - 1);

  logic            core_rst_q = 1'b1;
  logic [RC_W-1:0] rst_cnt    = '0;
  logic [PH_W-1:0] phase_q;

  // Reset filter: rst must stay high for two machine cycles
  always_ff @(posedge clk) begin
    if (!rst) begin
      rst_cnt    <= '0;
      core_rst_q <= 1'b0;
    end else if (rst_cnt == RC_W'(RST_CYCLES - 1)) begin
      core_rst_q <= 1'b1;
    end else begin
      rst_cnt <= rst_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (core_rst_q)          phase_q <= LAST;
    else if (phase_q == LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign core_rst    = core_rst_q;
  assign phase       = phase_q;
  assign cyc_start   = (phase_q == LAST);
  assign second_half = (phase_q >= PH_W'(HALF_LEN));
  assign ale_slot    = (phase_q < PH_W'(ALE_LEN)) ||
                       (second_half && (phase_q < PH_W'(HALF_LEN + ALE_LEN)));

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (core_rst_q)
    (phase_q == LAST) |=> (phase_q == '0)); // R1

endmodule

// File: rtl/bus_cycle_ctrl.sv
`timescale 1ns/1ps
module bus_cycle_ctrl
  import ext_bus_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int INT_CODE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              core_rst,
  input  logic              cyc_start,
  input  logic              ea_n,
  input  logic              fetch_req,
  input  logic              data_rd_req,
  input  logic              data_wr_req,
  input  logic              data_wide,
  input  logic              ale_quiet,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output cyc_kind_t         kind,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_wdata,
  output logic              cap_wide,
  output logic              cap_quiet
);
  logic ext_fetch;
  assign ext_fetch = fetch_goes_out(ea_n, 32'(addr), 32'(INT_CODE_BYTES));

  always_ff @(posedge clk) begin
    if (core_rst) begin
      kind      <= CYC_IDLE;
      cap_addr  <= '0;
      cap_wdata <= '0;
      cap_wide  <= 1'b0;
      cap_quiet <= 1'b0;
    end else if (cyc_start) begin
      kind      <= pick_kind(fetch_req, data_rd_req, data_wr_req, ext_fetch);
      cap_addr  <= addr;
      cap_wdata <= wr_data;
      cap_wide  <= data_wide;
      cap_quiet <= ale_quiet;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (core_rst)
    !cyc_start |=> ($stable(kind) && $stable(cap_addr) && $stable(cap_quiet))); // R10

endmodule

// File: rtl/bus_strobe_drv.sv
`timescale 1ns/1ps
module bus_strobe_drv
  import ext_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     core_rst,
  input  cyc_kind_t                kind,
  input  logic                     ale_slot,
  input  logic                     second_half,
  input  logic [ADDR_W-1:0]        cap_addr,
  input  logic [DATA_W-1:0]        cap_wdata,
  input  logic                     cap_wide,
  input  logic                     cap_quiet,
  input  logic [ADDR_W-DATA_W-1:0] hi_port_reg,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_addr
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] fetch_addr;
  logic              first_slot;

  assign next_addr  = ADDR_W'(second_code_addr(32'(cap_addr)));
  assign fetch_addr = second_half ? next_addr : cap_addr;
  assign first_slot = ale_slot && !second_half;

  always_comb begin
    ale     = 1'b0;
    psen_n  = 1'b1;
    rd_n    = 1'b1;
    wr_n    = 1'b1;
    ad_oe   = 1'b0;
    ad_out  = '0;
    hi_addr = hi_port_reg;
    if (!core_rst) begin
      unique case (kind)
        CYC_FETCH: begin
          ale     = ale_slot;
          psen_n  = ale_slot;
          ad_oe   = ale_slot;
          ad_out  = ale_slot ? fetch_addr[DATA_W-1:0] : '0;
          hi_addr = fetch_addr[ADDR_W-1 -: HI_W];
        end
        CYC_DRD, CYC_DWR: begin
          ale  = first_slot;
          rd_n = !((kind == CYC_DRD) && second_half);
          wr_n = !((kind == CYC_DWR) && second_half);
          if (first_slot) begin
            ad_oe  = 1'b1;
            ad_out = cap_addr[DATA_W-1:0];
          end else if (kind == CYC_DWR) begin
            ad_oe  = 1'b1;
            ad_out = cap_wdata;
          end
          if (cap_wide) hi_addr = cap_addr[ADDR_W-1 -: HI_W];
        end
        default: begin
          ale = ale_slot && !cap_quiet;
        end
      endcase
    end
  end

endmodule

// File: rtl/ext_bus_sequencer.sv
`timescale 1ns/1ps
module ext_bus_sequencer
  import ext_bus_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int INT_CODE_BYTES = 4096,
  parameter int STATE_TICKS    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ea_n,
  input  logic                     fetch_req,
  input  logic                     data_rd_req,
  input  logic                     data_wr_req,
  input  logic                     data_wide,
  input  logic                     ale_quiet,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-DATA_W-1:0] hi_port_reg,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_addr
);
  localparam int CYCLE_LEN = 6 * STATE_TICKS;
  localparam int HALF_LEN  = CYCLE_LEN / 2;
  localparam int PH_W      = $clog2(CYCLE_LEN);

  logic            core_rst;
  logic [PH_W-1:0] phase;
  logic            cyc_start;
  logic            ale_slot;
  logic            second_half;
  cyc_kind_t       kind;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_wdata;
  logic            cap_wide;
  logic            cap_quiet;

  bus_phase_gen #(.STATE_TICKS(STATE_TICKS)) u_phase (
    .clk(clk), .rst(rst), .core_rst(core_rst), .phase(phase),
    .cyc_start(cyc_start), .ale_slot(ale_slot), .second_half(second_half)
  );

  bus_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_CODE_BYTES(INT_CODE_BYTES)) u_ctrl (
    .clk(clk), .core_rst(core_rst), .cyc_start(cyc_start), .ea_n(ea_n),
    .fetch_req(fetch_req), .data_rd_req(data_rd_req), .data_wr_req(data_wr_req),
    .data_wide(data_wide), .ale_quiet(ale_quiet), .addr(addr), .wr_data(wr_data),
    .kind(kind), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
    .cap_wide(cap_wide), .cap_quiet(cap_quiet)
  );

  bus_strobe_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .core_rst(core_rst), .kind(kind), .ale_slot(ale_slot), .second_half(second_half),
    .cap_addr(cap_addr), .cap_wdata(cap_wdata), .cap_wide(cap_wide), .cap_quiet(cap_quiet),
    .hi_port_reg(hi_port_reg), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr)
  );

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (core_rst)
    !(!rd_n && !wr_n)); // R7
  AST_PSEN_NOT_DATA: assert property (@(posedge clk) disable iff (core_rst)
    !psen_n |-> (rd_n && wr_n)); // R5
  AST_DATA_NO_ALE: assert property (@(posedge clk) disable iff (core_rst)
    (!rd_n || !wr_n) |-> !ale); // R2
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (core_rst)
    !rd_n |-> !ad_oe); // R8
  AST_STROBE_START: assert property (@(posedge clk) disable iff (core_rst)
    ($fell(rd_n) || $fell(wr_n)) |-> (phase == PH_W'(HALF_LEN))); // R7
  AST_ALE_ALIGN: assert property (@(posedge clk) disable iff (core_rst)
    $rose(ale) |-> ((phase == '0) || (phase == PH_W'(HALF_LEN)))); // R1
  AST_PSEN_AFTER_ALE: assert property (@(posedge clk) disable iff (core_rst)
    $fell(psen_n) |-> $past(ale)); // R5

endmodule

// File: tb/sim_ext_bus_sequencer.sv
`timescale 1ns/1ps
module sim_ext_bus_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ea_n = 1'b1, fetch_req = 1'b0, data_rd_req = 1'b0, data_wr_req = 1'b0;
  logic data_wide = 1'b0, ale_quiet = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wr_data = '0, hi_port_reg = 8'hA5;
  logic ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0] ad_out, hi_addr;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag_ovr = "";

  // bench model of the sequencer
  int   m_phase = 11, m_cnt = 0, m_kind = 0;
  bit   m_rst = 1, m_wide = 0, m_quiet = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wdata = '0;

  always #2 clk = ~clk;

  ext_bus_sequencer u0 (
    .clk(clk), .rst(rst), .ea_n(ea_n), .fetch_req(fetch_req), .data_rd_req(data_rd_req),
    .data_wr_req(data_wr_req), .data_wide(data_wide), .ale_quiet(ale_quiet), .addr(addr),
    .wr_data(wr_data), .hi_port_reg(hi_port_reg), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr)
  );

  task automatic check(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (phase %0d kind %0d)",
               req, name, act, exp, m_phase, m_kind);
    end
  endtask

  function automatic int classify(input bit fetch, input bit rd, input bit wr,
                                  input bit ea_low, input logic [15:0] a);
    if (rd) return 2;
    if (wr) return 3;
    if (fetch && (!ea_low || a >= 16'h1000)) return 1;
    return 0;
  endfunction

  task automatic compare();
    bit in_a, first;
    bit e_ale = 0, e_psen = 1, e_rd = 1, e_wr = 1, e_oe = 0;
    logic [7:0] e_ad = '0, e_hi;
    logic [15:0] nxt;
    string t_ale;
    in_a  = m_phase inside {0, 1, 2, 6, 7, 8};
    first = (m_phase < 6);
    nxt   = m_addr + 16'd1;
    e_hi  = hi_port_reg;
    t_ale = "R1";
    if (m_rst) t_ale = "R11";
    else begin
      case (m_kind)
        1: begin
          e_ale = in_a; e_psen = in_a; e_oe = in_a;
          if (in_a) e_ad = first ? m_addr[7:0] : nxt[7:0];
          e_hi = first ? m_addr[15:8] : nxt[15:8];
          t_ale = m_quiet ? "R4" : "R1";
        end
        2, 3: begin
          e_ale = (m_phase < 3);
          if (!first) begin
            if (m_kind == 2) e_rd = 0; else e_wr = 0;
          end
          if (m_phase < 3) begin e_oe = 1; e_ad = m_addr[7:0]; end
          else if (m_kind == 3) begin e_oe = 1; e_ad = m_wdata; end
          if (m_wide) e_hi = m_addr[15:8];
          t_ale = "R2";
        end
        default: begin
          e_ale = in_a && !m_quiet;
          t_ale = m_quiet ? "R3" : "R1";
        end
      endcase
    end
    check(tag_ovr != "" ? tag_ovr : t_ale,  "ale",     ale,     e_ale);
    check(tag_ovr != "" ? tag_ovr : "R5",   "psen_n",  psen_n,  e_psen);
    check(tag_ovr != "" ? tag_ovr : "R7",   "rd_n",    rd_n,    e_rd);
    check(tag_ovr != "" ? tag_ovr : "R7",   "wr_n",    wr_n,    e_wr);
    check(tag_ovr != "" ? tag_ovr : "R8",   "ad_oe",   ad_oe,   e_oe);
    check(tag_ovr != "" ? tag_ovr : "R8",   "ad_out",  ad_out,  e_ad);
    check(tag_ovr != "" ? tag_ovr : "R9",   "hi_addr", hi_addr, e_hi);
  endtask

  task automatic tick();
    @(posedge clk);
    if (m_rst) begin
      m_phase = 11; m_kind = 0; m_addr = '0; m_wdata = '0; m_wide = 0; m_quiet = 0;
    end else if (m_phase == 11) begin
      m_phase = 0;
      m_kind  = classify(fetch_req, data_rd_req, data_wr_req, ea_n, addr);
      m_addr  = addr; m_wdata = wr_data; m_wide = data_wide; m_quiet = ale_quiet;
    end else m_phase++;
    if (!rst) begin m_cnt = 0; m_rst = 0; end
    else if (m_cnt == 23) m_rst = 1;
    else m_cnt++;
    #1;
    compare();
  endtask

  task automatic set_req(input bit f, input bit r, input bit w, input bit wide,
                         input bit q, input bit e, input logic [15:0] a, input logic [7:0] d);
    fetch_req = f; data_rd_req = r; data_wr_req = w; data_wide = wide;
    ale_quiet = q; ea_n = e; addr = a; wr_data = d;
  endtask

  task automatic to_phase(input int p);
    while (m_phase != p) tick();
  endtask

  // run one whole machine cycle with the given request captured at its start
  task automatic one_cycle(input bit f, input bit r, input bit w, input bit wide,
                           input bit q, input bit e, input logic [15:0] a, input logic [7:0] d);
    to_phase(11);
    set_req(f, r, w, wide, q, e, a, d);
    repeat (12) tick();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R11: power-up reset state, rst held well past two machine cycles
    tag_ovr = "R11";
    repeat (30) tick();
    hi_port_reg = 8'h3C;
    tick();
    rst = 1'b0;
    repeat (3) tick();
    tag_ovr = "";

    // R4: quiet bit with an external fetch forced by ea_n, address carry into high byte
    one_cycle(1, 0, 0, 0, 1, 0, 16'h12FF, 8'h00);
    // R1: free-running strobe in an idle cycle
    one_cycle(0, 0, 0, 0, 0, 1, 16'h0000, 8'h00);
    // R3: quiet idle cycle
    one_cycle(0, 0, 0, 0, 1, 1, 16'h0000, 8'h00);
    // R2 R7 R9: wide read, narrow write, quiet data cycle
    one_cycle(0, 1, 0, 1, 0, 1, 16'hBEEF, 8'h00);
    one_cycle(0, 0, 1, 0, 0, 1, 16'h4321, 8'h5A);
    one_cycle(0, 0, 1, 1, 1, 1, 16'h8001, 8'hC3);
    // R7: read and write together, data over fetch
    one_cycle(1, 1, 1, 1, 0, 0, 16'h7777, 8'h11);
    // R6: internal fetch below limit, external fetch at and above limit
    tag_ovr = "R6";
    one_cycle(1, 0, 0, 0, 0, 1, 16'h0FFF, 8'h00);
    one_cycle(1, 0, 0, 0, 1, 1, 16'h0100, 8'h00);
    one_cycle(1, 0, 0, 0, 1, 1, 16'h1000, 8'h00);
    one_cycle(1, 0, 0, 0, 0, 1, 16'hFFFF, 8'h00);
    tag_ovr = "";

    // R10: requests change in mid-cycle; capture holds
    tag_ovr = "R10";
    to_phase(11);
    set_req(1, 0, 0, 0, 0, 0, 16'h2468, 8'h00);
    repeat (5) tick();
    set_req(0, 0, 1, 1, 1, 1, 16'h9999, 8'hEE);
    hi_port_reg = 8'h81;
    repeat (7) tick();
    repeat (12) tick();
    tag_ovr = "";

    // R11: short pulse of 23 edges leaves the sequence running
    tag_ovr = "R11";
    set_req(1, 0, 0, 0, 0, 0, 16'h0F0F, 8'h00);
    to_phase(4);
    rst = 1'b1;
    repeat (23) tick();
    rst = 1'b0;
    repeat (14) tick();
    // full-length pulse, then release timing
    rst = 1'b1;
    repeat (26) tick();
    rst = 1'b0;
    repeat (14) tick();
    tag_ovr = "";

    // constrained random traffic
    for (int i = 0; i < 4800; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        logic [15:0] a;
        case ($urandom_range(0, 3))
          0: a = 16'h0FFF;
          1: a = 16'h1000;
          2: a = 16'hFFFF;
          default: a = 16'($urandom);
        endcase
        set_req($urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
                a, 8'($urandom));
      end
      if ($urandom_range(0, 15) == 0) hi_port_reg = 8'($urandom);
      tick();
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule